// File: doc/BRIEF.md
# Odd-Multiple Table Constant Multiplier

This block multiplies an 8-bit unsigned sample by a coefficient H held in a small on-block table. Rather than keeping every product of H with a 4-bit value, the table keeps only the eight odd multiples H, 3H, 5H, 7H, 9H, 11H, 13H and 15H. Each nibble of the sample is reduced to its odd part. That odd part selects a table word. The word is then shifted left by the number of trailing zero bits the nibble had. A nibble of all zeros contributes nothing.

The two nibbles are handled side by side and read the table through two independent read ports. The upper partial product is weighted by 16 and added to the lower one. The coefficient is written through a load port, which fills all eight words in one cycle. A product appears two clock cycles after its sample, together with a matching valid strobe. Between strobes the product output keeps its last value.

Top module: `oddmul_lut_mult`

## Requirements
- R1: A cycle with coef_load_i high writes table word k (k = 0..7) with (2k+1)·coef_i. Every later product is computed with that coefficient.
- R2: A non-zero nibble selects table address (odd part of the nibble − 1)/2, where the odd part is the nibble shifted right past its trailing zeros. For example 1100 and 0011 both select 001, and 1111 selects 111.
- R3: The selected word is shifted left by the nibble's trailing-zero count, which is 0 to 3. For example nibble 1000 gives 8H and nibble 0110 gives 6H.
- R4: A nibble of 0000 forces that half's partial product to zero, whatever the table holds.
- R5: out_prod_o equals H·in_data_i for every one of the 256 input values and for any loaded H, including the largest H.
- R6: out_valid_o is high exactly two cycles after in_valid_i was high. The product for that sample is on out_prod_o in the same cycle.
- R7: While out_valid_o is low, out_prod_o keeps its previous value.
- R8: A sample presented in the same cycle as a load uses the new coefficient. A sample presented one cycle before the load uses the old one.
- R9: After reset out_valid_o and out_prod_o are zero and every table word is zero, so any product is 0 until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Sample strobe |
| in_data_i | input | 8 | Unsigned sample |
| coef_load_i | input | 1 | Coefficient write strobe |
| coef_i | input | COEF_W | Coefficient H |
| out_valid_o | output | 1 | Product strobe, two cycles after in_valid_i |
| out_prod_o | output | COEF_W+8 | Product H·sample |

## Verification
A coefficient load and a sample can arrive in the same cycle. The table is only read one cycle after the sample is taken, so the order between the two decides which H is used. The bench drives a load together with a sample and expects the product with the new H. It also issues a sample followed one cycle later by a load, and expects that sample to be multiplied by the old H, since its table read happens before the write takes effect.

// File: rtl/oddmul_pkg.sv
package oddmul_pkg;
  typedef struct packed {
    logic [2:0] addr;   // odd part index
    logic [1:0] shamt;  // trailing zero count
    logic       zero;   // nibble is 0000
  } nib_code_t;
endpackage

// File: rtl/oddmul_nib_enc.sv
module oddmul_nib_enc
  import oddmul_pkg::*;
(
  input  logic [3:0] nib_i,
  output nib_code_t  code_o
);
  logic [3:0] odd_part;

  always_comb begin
    code_o = '0;
    casez (nib_i)
      4'b???1: code_o.shamt = 2'd0;
      4'b??10: code_o.shamt = 2'd1;
      4'b?100: code_o.shamt = 2'd2;
      4'b1000: code_o.shamt = 2'd3;
      default: code_o.zero  = 1'b1;
    endcase
    odd_part    = nib_i >> code_o.shamt;
    code_o.addr = odd_part[3:1];
  end

  // address and shift must rebuild the nibble
  always_comb begin
    if (!code_o.zero)
      assert_enc_map_R2: assert ((7'({code_o.addr, 1'b1}) << code_o.shamt) == 7'(nib_i));
  end
endmodule

// File: rtl/oddmul_store.sv
module oddmul_store #(
  parameter int COEF_W = 8,
  parameter int PORTS  = 2,
  localparam int WORD_W = COEF_W + 4,
  localparam int DEPTH  = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [COEF_W-1:0]            coef_i,
  input  logic [PORTS-1:0][2:0]        rd_addr_i,
  output logic [PORTS-1:0][WORD_W-1:0] rd_data_o
);
  logic [DEPTH-1:0][WORD_W-1:0] word_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_word
    localparam logic [WORD_W-1:0] ODD_MUL = WORD_W'(2 * k + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     word_q[k] <= '0;
      else if (load_i) word_q[k] <= WORD_W'(coef_i) * ODD_MUL;
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign rd_data_o[p] = word_q[rd_addr_i[p]];
  end

  assert_load_base_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> word_q[0] == WORD_W'($past(coef_i)));
  assert_load_top_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> word_q[DEPTH-1] == (word_q[0] << 4) - word_q[0]);
endmodule

// File: rtl/oddmul_nib_scale.sv
module oddmul_nib_scale
  import oddmul_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic [WORD_W-1:0] word_i,
  input  nib_code_t         code_i,
  output logic [WORD_W-1:0] part_o
);
  assign part_o = code_i.zero ? '0 : (word_i << code_i.shamt);
endmodule

// File: rtl/oddmul_lut_mult.sv
module oddmul_lut_mult
  import oddmul_pkg::*;
#(
  parameter int COEF_W = 8,
  localparam int IN_W   = 8,
  localparam int NIBS   = IN_W / 4,
  localparam int WORD_W = COEF_W + 4,
  localparam int PROD_W = COEF_W + IN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [IN_W-1:0]   in_data_i,
  input  logic              coef_load_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic              out_valid_o,
  output logic [PROD_W-1:0] out_prod_o
);
  nib_code_t                      code_d [NIBS];
  nib_code_t                      code_q [NIBS];
  logic [NIBS-1:0][2:0]           rd_addr;
  logic [NIBS-1:0][WORD_W-1:0]    rd_data;
  logic [NIBS-1:0][WORD_W-1:0]    part;
  logic                           v1_q;
  logic [PROD_W-1:0]              sum;

  for (genvar n = 0; n < NIBS; n++) begin : g_nib
    oddmul_nib_enc u_enc (
      .nib_i  (in_data_i[4*n +: 4]),
      .code_o (code_d[n])
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         code_q[n] <= '0;
      else if (in_valid_i) code_q[n] <= code_d[n];
    end
    assign rd_addr[n] = code_q[n].addr;
    oddmul_nib_scale #(.WORD_W(WORD_W)) u_scale (
      .word_i (rd_data[n]),
      .code_i (code_q[n]),
      .part_o (part[n])
    );
  end

  oddmul_store #(.COEF_W(COEF_W), .PORTS(NIBS)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (coef_load_i),
    .coef_i    (coef_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  always_comb begin
    sum = '0;
    for (int n = 0; n < NIBS; n++) sum = sum + (PROD_W'(part[n]) << (4 * n));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q        <= 1'b0;
      out_valid_o <= 1'b0;
      out_prod_o  <= '0;
    end else begin
      v1_q        <= in_valid_i;
      out_valid_o <= v1_q;
      if (v1_q) out_prod_o <= sum;
    end
  end

  assert_stage_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> v1_q);
  assert_out_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1_q |=> out_valid_o);
  assert_no_spurious_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v1_q |=> !out_valid_o);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v1_q |=> $stable(out_prod_o));
  assert_zero_nibs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_q && code_q[0].zero && code_q[NIBS-1].zero) |=> out_prod_o == '0);
endmodule

// File: tb/sim_oddmul_lut_mult.sv
module sim_oddmul_lut_mult;
  localparam int COEF_W = 8;
  localparam int PROD_W = COEF_W + 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              in_valid_i = 1'b0;
  logic [7:0]        in_data_i = '0;
  logic              coef_load_i = 1'b0;
  logic [COEF_W-1:0] coef_i = '0;
  logic              out_valid_o;
  logic [PROD_W-1:0] out_prod_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  oddmul_lut_mult #(.COEF_W(COEF_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .coef_load_i(coef_load_i), .coef_i(coef_i),
    .out_valid_o(out_valid_o), .out_prod_o(out_prod_o)
  );

  task automatic check(string req, logic [PROD_W-1:0] act, logic [PROD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(logic [COEF_W-1:0] h);
    @(negedge clk);
    coef_load_i = 1'b1; coef_i = h;
    @(negedge clk);
    coef_load_i = 1'b0;
  endtask

  // sample at negedge, result seen two negedges later
  task automatic mult(logic [7:0] x, output logic [PROD_W-1:0] p, output logic v);
    @(negedge clk);
    in_valid_i = 1'b1; in_data_i = x;
    @(negedge clk);
    in_valid_i = 1'b0;
    @(negedge clk);
    p = out_prod_o; v = out_valid_o;
  endtask

  task automatic t_reset;
    logic [PROD_W-1:0] p; logic v;
    check("R9 valid after reset", PROD_W'(out_valid_o), '0);
    check("R9 product after reset", out_prod_o, '0);
    mult(8'hFF, p, v);
    check("R9 empty table", p, '0);
  endtask

  task automatic t_sweep(logic [COEF_W-1:0] h);
    logic [PROD_W-1:0] p; logic v; int bad;
    load(h);
    bad = 0;
    for (int x = 0; x < 256; x++) begin
      mult(8'(x), p, v);
      if (p !== PROD_W'(h) * PROD_W'(x) || v !== 1'b1) begin
        bad++;
        $display("FAIL R5 h=%0d x=%0d: actual=%0d expected=%0d", h, x, p, PROD_W'(h) * PROD_W'(x));
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic t_nibbles;
    logic [PROD_W-1:0] p; logic v;
    load(8'd37);
    mult(8'h08, p, v); check("R3 nibble 1000", p, 16'd296);
    mult(8'h06, p, v); check("R3 nibble 0110", p, 16'd222);
    mult(8'h0C, p, v); check("R2 nibble 1100", p, 16'd444);
    mult(8'h0F, p, v); check("R2 nibble 1111", p, 16'd555);
    mult(8'hA0, p, v); check("R2 upper 1010", p, 16'd5920);
    mult(8'h00, p, v); check("R4 both zero", p, '0);
    mult(8'h30, p, v); check("R4 lower zero", p, 16'd1776);
    mult(8'h05, p, v); check("R4 upper zero", p, 16'd185);
  endtask

  task automatic t_timing;
    logic [PROD_W-1:0] p;
    load(8'd9);
    @(negedge clk); in_valid_i = 1'b1; in_data_i = 8'd20;
    @(negedge clk); in_valid_i = 1'b0;
    check("R6 no valid after one cycle", PROD_W'(out_valid_o), '0);
    @(negedge clk);
    check("R6 valid after two cycles", PROD_W'(out_valid_o), 1);
    check("R6 product with valid", out_prod_o, 16'd180);
    in_data_i = 8'd77;
    @(negedge clk);
    check("R6 valid single cycle", PROD_W'(out_valid_o), '0);
    p = out_prod_o;
    @(negedge clk); @(negedge clk);
    check("R7 product holds", out_prod_o, 16'd180);
    check("R7 product holds early", p, 16'd180);
  endtask

  task automatic t_collision;
    logic [PROD_W-1:0] p; logic v;
    load(8'd3);
    // load and sample in the same cycle: new coefficient
    @(negedge clk);
    coef_load_i = 1'b1; coef_i = 8'd11; in_valid_i = 1'b1; in_data_i = 8'd50;
    @(negedge clk);
    coef_load_i = 1'b0; in_valid_i = 1'b0;
    @(negedge clk);
    check("R8 same-cycle load uses new H", out_prod_o, 16'd550);
    // sample then load one cycle later: old coefficient
    @(negedge clk);
    in_valid_i = 1'b1; in_data_i = 8'd50;
    @(negedge clk);
    in_valid_i = 1'b0; coef_load_i = 1'b1; coef_i = 8'd200;
    @(negedge clk);
    coef_load_i = 1'b0;
    check("R8 earlier sample uses old H", out_prod_o, 16'd550);
    mult(8'd50, p, v);
    check("R1 later sample uses new H", p, 16'd10000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_nibbles();
    t_timing();
    t_collision();
    t_sweep(8'd1);
    t_sweep(8'd173);
    t_sweep(8'd255);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule